// File: doc/BRIEF.md
# Capture/Reload Interval Timer

This block is a 16-bit up-counting timer for a larger chip. Software drives it through a small register port: one control word, the live count and a shared capture/reload register. The counter advances on ticks from one of two sources. The first is the system clock after a prescaler that divides by four to the power N. The second is the falling edges seen on an external count pin. A run bit in the control word gates every tick.

The block has two modes. In capture mode the counter rolls from its maximum back to zero. A falling edge on the capture pin, when the external-enable bit allows it, copies the live count into the shared register and sets an event flag. In reload mode a rollover loads the counter from the shared register instead of zero, so the block produces a periodic overflow. Every rollover sets an overflow flag. The two flags drive one interrupt line through separate enable inputs. The block has no streaming data path: the register port and all pins are plain level signals with no handshake.

Control word bit layout, which software depends on: bit 0 mode (1 capture, 0 reload), bit 2 run, bit 3 external enable, bit 6 event flag, bit 7 overflow flag, bits 10:8 prescale exponent N, bit 15 count source (0 prescaled clock, 1 count pin). Every other bit reads 0. Register select codes on `wr_sel`/`rd_sel`: 0 control, 1 count, 2 capture/reload, 3 nothing (the write is ignored and the read returns 0).

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the control word, the count and the capture/reload register all read 0, and `irq` is low.
- R2: In capture mode (bit 0 = 1), a tick at count FFFFh gives 0000h, sets the overflow flag (bit 7), and counting continues on the following ticks.
- R3: In capture mode with bit 3 = 1, a falling edge on `capture_pin` stores the count into the capture/reload register and sets the event flag (bit 6). The register updates on the third rising clock edge after the pin changes.
- R4: A capture needs both capture mode and bit 3 = 1. A falling edge with bit 3 = 0, a falling edge in reload mode, or any rising edge leaves the capture/reload register and the event flag unchanged.
- R5: While the run bit (bit 2) is 0, the count changes only through software writes.
- R6: With bit 15 = 0, the count advances once every 4^N clock cycles, where N is bits 10:8. With N = 0 it advances every cycle.
- R7: In reload mode (bit 0 = 0), a tick at count FFFFh loads the count from the capture/reload register and sets the overflow flag.
- R8: The flags stay set until software writes 0 to their bit in the control word. Writing 1 to a flag bit has no effect.
- R9: `irq` equals (overflow flag AND `ovf_ie`) OR (event flag AND `evt_ie`).
- R10: With bit 15 = 1, the count advances once for each falling edge on `count_pin` while run is 1.
- R11: A hardware flag set in the same cycle as a software write of 0 to that flag leaves the flag set.
- R12: Writes to the count and to the capture/reload register show on the next clock edge. A capture in the same cycle as a software write to the capture/reload register keeps the captured value.
- R13: Control-word bits 1, 4, 5 and 14:11 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target (0 control, 1 count, 2 capture/reload) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source, same codes as wr_sel |
| rd_data | output | 16 | Read data, combinational |
| count_pin | input | 1 | External count input, counted on falling edges |
| capture_pin | input | 1 | External capture trigger, falling edge |
| ovf_ie | input | 1 | Overflow interrupt enable |
| evt_ie | input | 1 | Capture-event interrupt enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: a 16-bit counter, a 3-bit prescale field and a two-stage pin synchronizer. With these values the prescale exponents 0, 1 and 2 can be tested and counted exactly in a few dozen cycles. Presetting the count to FFFEh makes both kinds of rollover reachable in a handful of ticks. The known three-edge pin latency lets the bench line up a capture with a software write in the same cycle, which exercises both priority rules.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CTL_W      = 16;
  localparam int PSC_W      = 3;
  localparam int B_MODE     = 0;
  localparam int B_RUN      = 2;
  localparam int B_EXTEN    = 3;
  localparam int B_EVT      = 6;
  localparam int B_OVF      = 7;
  localparam int B_PSC_LO   = 8;
  localparam int B_SRC      = 15;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CAPT  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             src_ext;
    logic [PSC_W-1:0] psc_n;
    logic             ovf_flag;
    logic             evt_flag;
    logic             ext_en;
    logic             run;
    logic             cap_mode;
  } ctrl_t;
endpackage

// File: rtl/crt_pin_sync.sv
module crt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  // Idle level is high, so reset to 1 to avoid a false edge after reset.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= chain[STAGES-1];
  end

  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
  parameter int PSC_BITS = crt_pkg::PSC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PSC_BITS-1:0] psc_n,
  output logic                tick
);
  localparam int PRE_W = 2 * ((1 << PSC_BITS) - 1);

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  assign mask = ~({PRE_W{1'b1}} << {psc_n, 1'b0});
  assign tick = run & (&(pre | ~mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (run) pre <= pre + 1'b1;
    else          pre <= '0;
  end

  // R6: with a nonzero exponent, ticks never come on back-to-back cycles
  p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc_n != '0) |=> (!tick || psc_n != $past(psc_n)));
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cap_mode,
  input  logic             cap_fire,
  input  logic             cnt_wr,
  input  logic             cap_wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cap_reg,
  output logic             ovf_evt
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  logic at_max;
  assign at_max  = (count == MAXV);
  assign ovf_evt = tick & at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (cnt_wr)            count <= wdata;
    else if (tick && at_max)    count <= cap_mode ? '0 : cap_reg;
    else if (tick)              count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_reg <= '0;
    else if (cap_fire) cap_reg <= count;
    else if (cap_wr)   cap_reg <= wdata;
  end

  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  p_capture_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cap_reg == $past(count)));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_max && cap_mode && !cnt_wr) |=> (count == '0));

  p_reload_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_max && !cap_mode && !cnt_wr) |=> (count == $past(cap_reg)));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [15:0] rd_data,
  input  logic        count_pin,
  input  logic        capture_pin,
  input  logic        ovf_ie,
  input  logic        evt_ie,
  output logic        irq
);
  import crt_pkg::*;

  ctrl_t            ctl;
  logic             ctl_wr, cnt_wr, cap_wr;
  logic             cnt_fall, cap_fall, psc_tick, tick, cap_fire, ovf_evt;
  logic [WIDTH-1:0] count, cap_reg;
  logic             unused_ok;

  assign ctl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign cnt_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
  assign cap_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CAPT);
  assign unused_ok = ^{wr_data[14:11], wr_data[5:4], wr_data[1]};

  crt_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(cnt_fall));

  crt_pin_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin(capture_pin), .fall(cap_fall));

  crt_prescaler #(.PSC_BITS(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctl.run && !ctl.src_ext),
    .psc_n(ctl.psc_n), .tick(psc_tick));

  assign tick     = ctl.run && (ctl.src_ext ? cnt_fall : psc_tick);
  assign cap_fire = cap_fall && ctl.ext_en && ctl.cap_mode;

  crt_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_mode(ctl.cap_mode),
    .cap_fire(cap_fire), .cnt_wr(cnt_wr), .cap_wr(cap_wr),
    .wdata(wr_data[WIDTH-1:0]), .count(count), .cap_reg(cap_reg),
    .ovf_evt(ovf_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (ctl_wr) begin
        ctl.src_ext  <= wr_data[B_SRC];
        ctl.psc_n    <= wr_data[B_PSC_LO +: PSC_W];
        ctl.ext_en   <= wr_data[B_EXTEN];
        ctl.run      <= wr_data[B_RUN];
        ctl.cap_mode <= wr_data[B_MODE];
      end
      // flags: software may only clear; a hardware set always wins
      ctl.ovf_flag <= ovf_evt  | (ctl.ovf_flag & (~ctl_wr | wr_data[B_OVF]));
      ctl.evt_flag <= cap_fire | (ctl.evt_flag & (~ctl_wr | wr_data[B_EVT]));
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_CTRL: begin
        rd_data[B_SRC]              = ctl.src_ext;
        rd_data[B_PSC_LO +: PSC_W]  = ctl.psc_n;
        rd_data[B_OVF]              = ctl.ovf_flag;
        rd_data[B_EVT]              = ctl.evt_flag;
        rd_data[B_EXTEN]            = ctl.ext_en;
        rd_data[B_RUN]              = ctl.run;
        rd_data[B_MODE]             = ctl.cap_mode;
      end
      SEL_COUNT: rd_data = 16'(count);
      SEL_CAPT:  rd_data = 16'(cap_reg);
      default:   rd_data = '0;
    endcase
  end

  assign irq = (ctl.ovf_flag & ovf_ie) | (ctl.evt_flag & evt_ie);

  p_evt_only_by_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> !$rose(ctl.evt_flag));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ovf_flag && !ctl_wr) |=> ctl.ovf_flag);

  p_flag_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> ctl.evt_flag);
endmodule

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        count_pin = 1'b1;
  logic        capture_pin = 1'b1;
  logic        ovf_ie = 1'b0;
  logic        evt_ie = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  cap_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .count_pin(count_pin), .capture_pin(capture_pin),
    .ovf_ie(ovf_ie), .evt_ie(evt_ie), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R1 count", v, 16'h0000);
    rd(2'd2, v); check("R1 capt", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_layout();
    logic [15:0] v;
    wr(2'd0, 16'h78F2);
    rd(2'd0, v); check("R13 unused bits and R8 write-one", v, 16'h0000);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0005);
    idle(2);
    wr(2'd0, 16'h00C1);
    rd(2'd1, v); check("R2 count after wrap", v, 16'h0002);
    rd(2'd0, v); check("R2 ovf flag", v, 16'h0081);
    ovf_ie = 1'b1; #1;
    check("R9 irq ovf enabled", {15'd0, irq}, 16'h0001);
    ovf_ie = 1'b0; #1;
    check("R9 irq ovf masked", {15'd0, irq}, 16'h0000);
    wr(2'd0, 16'h0001);
    rd(2'd0, v); check("R8 ovf cleared by 0", v, 16'h0001);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    wr(2'd2, 16'h1230);
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'h0004);
    idle(2);
    wr(2'd0, 16'h0080);
    rd(2'd1, v); check("R7 reload count", v, 16'h1232);
    rd(2'd0, v); check("R7 ovf flag", v, 16'h0080);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    wr(2'd1, 16'h0042);
    idle(10);
    rd(2'd1, v); check("R5 held while stopped", v, 16'h0042);
  endtask

  task automatic t_prescale(input logic [2:0] n, input int w, input logic [15:0] exp);
    logic [15:0] v;
    wr(2'd1, 16'h0000);
    wr(2'd0, {5'd0, n, 8'h05});
    idle(w);
    wr(2'd0, {5'd0, n, 8'h01});
    rd(2'd1, v); check("R6 prescaled count", v, exp);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(2'd1, 16'h4321);
    wr(2'd0, 16'h0009);
    @(negedge clk); capture_pin = 1'b0;
    idle(2);
    rd(2'd2, v); check("R3 not yet at two edges", v, 16'h1230);
    idle(1);
    rd(2'd2, v); check("R3 captured at third edge", v, 16'h4321);
    rd(2'd0, v); check("R3 evt flag", v, 16'h0049);
    evt_ie = 1'b1; #1;
    check("R9 irq evt", {15'd0, irq}, 16'h0001);
    evt_ie = 1'b0;
    wr(2'd1, 16'h5000);
    capture_pin = 1'b1; idle(5);
    rd(2'd2, v); check("R4 rising edge ignored", v, 16'h4321);
    wr(2'd0, 16'h0009);
  endtask

  task automatic t_no_capture();
    logic [15:0] v;
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'h5555);
    @(negedge clk); capture_pin = 1'b0; idle(5);
    capture_pin = 1'b1; idle(5);
    rd(2'd2, v); check("R4 ext enable off", v, 16'h4321);
    rd(2'd0, v); check("R4 no evt flag", v, 16'h0001);
    wr(2'd0, 16'h0008);
    @(negedge clk); capture_pin = 1'b0; idle(5);
    capture_pin = 1'b1; idle(5);
    rd(2'd2, v); check("R4 reload mode no capture", v, 16'h4321);
    rd(2'd0, v); check("R4 reload mode no flag", v, 16'h0008);
  endtask

  task automatic t_ext_count();
    logic [15:0] v;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h8005);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); count_pin = 1'b0; idle(4);
      count_pin = 1'b1; idle(4);
    end
    wr(2'd0, 16'h8001);
    rd(2'd1, v); check("R10 external edges counted", v, 16'h0003);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    wr(2'd1, 16'h0777);
    wr(2'd0, 16'h0049);
    @(negedge clk); capture_pin = 1'b0;
    idle(2);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0009;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd0, v); check("R11 hw set beats clear", v, 16'h0049);
    capture_pin = 1'b1; idle(5);
    wr(2'd1, 16'h0888);
    @(negedge clk); capture_pin = 1'b0;
    idle(2);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'hAAAA;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, v); check("R12 capture beats write", v, 16'h0888);
    capture_pin = 1'b1; idle(5);
    wr(2'd2, 16'h0BCD);
    rd(2'd2, v); check("R12 write lands next edge", v, 16'h0BCD);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_layout();
    t_wrap();
    t_reload();
    t_stopped();
    t_prescale(3'd1, 14, 16'h0004);
    t_prescale(3'd2, 30, 16'h0002);
    t_capture();
    t_no_capture();
    t_ext_count();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule